// File: doc/BRIEF.md
# Video Control Command Stream Decoder

This block sits behind a bulk transport and turns a byte stream of display commands into the parallel control values a video timing engine needs. Each command opens with a lead byte and an opcode. The decoder knows two opcodes. A register write carries an address byte and a data byte. A copy carries a source address, a pixel count and a destination address, and the block hands these on as a single-cycle event. It does not touch memory itself.

The written values sit in a shadow register file. While the registers are unlocked, each write reaches the live outputs at once. After a lock write, new values stay in the shadow file. The matching unlock write then moves every staged value to the live outputs on the same clock edge, so the timing engine never sees a half-updated mode.

The live outputs are:
- the colour depth select;
- two 24-bit frame base addresses;
- twelve 16-bit timing words;
- a 16-bit pixel clock word;
- the blank mode.

A malformed lead byte or an unknown opcode raises a sticky error flag. The parser then hunts for the next lead byte. Input is accepted on every cycle.

Top module: `vidcmd_decoder`

## Requirements
- R1: After reset all live outputs are zero, `sync_err` and `copy_valid` are 0, and the registers are unlocked.
- R2: Every command starts with lead byte 0xAF. A register write is 0xAF, opcode 0x20, an address byte and a data byte. While unlocked, the addressed value appears on the live outputs in the cycle after the data byte is accepted. Live outputs never change unless a byte was accepted on the previous edge.
- R3: Writing data 0x00 to address 0xFF locks the registers. While locked, writes change no live output. Writing data 0xFF to address 0xFF unlocks them, and every staged value appears on the live outputs in the same cycle.
- R4: Base address `base16_addr` is held at addresses 0x20, 0x21 and 0x22. Base address `base8_addr` is held at 0x26, 0x27 and 0x28. In both cases the lowest address holds the most significant byte.
- R5: Timing word `timing_vals[i]` (i = 0..11) is made of two bytes. The byte at address 1+2i is the high byte and the byte at 2+2i is the low byte.
- R6: The pixel clock word `pix_clock` takes its low byte from address 0x1B and its high byte from 0x1C.
- R7: `blank_mode` is the byte at address 0x1F, with codes 0x00 syncs on, 0x01 blanked, 0x05 standby and 0x07 power down. `depth_24` is bit 0 of address 0x00 (0 = 16 bpp, 1 = 24 bpp).
- R8: A copy is 0xAF, opcode 0x6A, then 3 source bytes (most significant first), 1 count byte and 3 destination bytes. One cycle after the last byte, `copy_valid` pulses for exactly one cycle with those fields.
- R9: A first byte other than 0xAF, or an opcode other than 0x20 or 0x6A, sets `sync_err`. The flag stays set until reset. The parser then decodes the next command that starts with 0xAF normally.
- R10: `in_ready` is 1 in every cycle, including back-to-back commands.
- R11: A write to address 0xFF with data other than 0x00 or 0xFF, or a write to an address with no output, changes no live output and does not change the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte accepted (always 1) |
| depth_24 | output | 1 | Colour depth select |
| base16_addr | output | 24 | 16 bpp frame base address |
| base8_addr | output | 24 | 8 bpp frame base address |
| timing_vals | output | 12x16 | Timing words, element i from addresses 1+2i and 2+2i |
| pix_clock | output | 16 | Pixel clock word |
| blank_mode | output | 8 | Blank mode code |
| copy_valid | output | 1 | One-cycle copy event |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| sync_err | output | 1 | Sticky framing error |

## Verification
The bench writes distinct byte values to both halves of each multi-byte register. This separates high-byte-first words from the low-byte-first pixel clock and catches any swap in the base address byte order.

A sequence of lock, several writes, then unlock tells staged values apart from live ones and shows that the whole commit lands on one edge. Two copies sent back to back, with no idle cycle between them, show that neither the pulse nor the fields bleed across commands.

Finally, three inputs probe error handling: an unknown opcode, stray bytes, and a lock-address write with an odd data value. Each is followed by a valid command, which shows that the parser resynchronises and that the stray input left the register state alone.

// File: rtl/vidcmd_pkg.sv
// Package: shared stream codes, register addresses and parser state type.
// Assumes byte-wide stream and byte-addressed video control registers.
package vidcmd_pkg;
    localparam logic [7:0] LEAD_BYTE   = 8'hAF;
    localparam logic [7:0] OP_REG_WR   = 8'h20;
    localparam logic [7:0] OP_COPY     = 8'h6A;
    localparam logic [7:0] LOCK_ADDR   = 8'hFF;
    localparam logic [7:0] LOCK_DATA   = 8'h00;
    localparam logic [7:0] UNLOCK_DATA = 8'hFF;

    localparam int ADDR_BYTES  = 3;
    localparam int COPY_BYTES  = 2 * ADDR_BYTES + 1;

    localparam int DEPTH_REG   = 8'h00;
    localparam int TIM_BASE    = 8'h01;
    localparam int PIXCLK_REG  = 8'h1B;
    localparam int BLANK_REG   = 8'h1F;
    localparam int BASE16_REG  = 8'h20;
    localparam int BASE8_REG   = 8'h26;

    typedef enum logic [2:0] {
        PS_HUNT,
        PS_OPCODE,
        PS_ADDR,
        PS_DATA,
        PS_COPY
    } parse_state_t;
endpackage

// File: rtl/vidcmd_parser.sv
// Parser: walks the command framing byte by byte. Emits a register write
// strobe on the data byte and indexed copy payload strobes. Sets a sticky
// error on a bad lead byte or unknown opcode, then hunts for the lead byte.
// Assumes every byte with in_valid high is consumed in that cycle.
module vidcmd_parser
    import vidcmd_pkg::*;
#(
    parameter int PAYLOAD_BYTES = COPY_BYTES,
    localparam int IDX_W = $clog2(PAYLOAD_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             wr_en,
    output logic [7:0]       wr_addr,
    output logic [7:0]       wr_data,
    output logic             cp_en,
    output logic [IDX_W-1:0] cp_idx,
    output logic [7:0]       cp_data,
    output logic             err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAYLOAD_BYTES - 1);

    parse_state_t     state;
    logic [7:0]       addr_q;
    logic [IDX_W-1:0] cnt_q;

    // Framing state machine, address capture, payload counter and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_HUNT;
            addr_q <= '0;
            cnt_q  <= '0;
            err    <= 1'b0;
        end else if (in_valid) begin
            unique case (state)
                PS_HUNT: begin
                    if (in_data == LEAD_BYTE) state <= PS_OPCODE;
                    else                      err   <= 1'b1;
                end
                PS_OPCODE: begin
                    if (in_data == OP_REG_WR) begin
                        state <= PS_ADDR;
                    end else if (in_data == OP_COPY) begin
                        state <= PS_COPY;
                        cnt_q <= '0;
                    end else begin
                        state <= PS_HUNT;
                        err   <= 1'b1;
                    end
                end
                PS_ADDR: begin
                    addr_q <= in_data;
                    state  <= PS_DATA;
                end
                PS_DATA: state <= PS_HUNT;
                PS_COPY: begin
                    if (cnt_q == LAST_IDX) state <= PS_HUNT;
                    else                   cnt_q <= cnt_q + 1'b1;
                end
                default: state <= PS_HUNT;
            endcase
        end
    end

    // Strobes for the register bank and copy capture.
    always_comb begin
        wr_en   = in_valid && (state == PS_DATA);
        wr_addr = addr_q;
        wr_data = in_data;
        cp_en   = in_valid && (state == PS_COPY);
        cp_idx  = cnt_q;
        cp_data = in_data;
    end
endmodule

// File: rtl/vidcmd_regbank.sv
// Register bank: shadow and live byte arrays with a lock flag. Writes always
// land in the shadow array and also in the live array while unlocked.
// Unlock copies the whole shadow array into the live array on one edge.
// Assumes addresses at or above REG_BYTES other than the lock address are ignored.
module vidcmd_regbank
    import vidcmd_pkg::*;
#(
    parameter int REG_BYTES = 41,
    localparam int IDX_W = $clog2(REG_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [7:0]                wr_data,
    output logic [REG_BYTES-1:0][7:0] live,
    output logic                      locked
);
    localparam logic [7:0] TOP_ADDR = 8'(REG_BYTES - 1);

    logic [REG_BYTES-1:0][7:0] shadow;
    logic                      in_map;
    logic [IDX_W-1:0]          idx;

    // Decode whether the write targets a stored byte.
    always_comb begin
        in_map = wr_en && (wr_addr <= TOP_ADDR);
        idx    = wr_addr[IDX_W-1:0];
    end

    // Shadow update, live update or bulk commit, and lock tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            live   <= '0;
            locked <= 1'b0;
        end else begin
            if (in_map) begin
                shadow[idx] <= wr_data;
                if (!locked) live[idx] <= wr_data;
            end
            if (wr_en && wr_addr == LOCK_ADDR) begin
                if (wr_data == LOCK_DATA) begin
                    locked <= 1'b1;
                end else if (wr_data == UNLOCK_DATA) begin
                    locked <= 1'b0;
                    live   <= shadow;
                end
            end
        end
    end
endmodule

// File: rtl/vidcmd_copycap.sv
// Copy capture: stores the copy payload bytes by index and raises a
// one-cycle valid after the last byte. Fields are ordered source (most
// significant byte first), count, destination (most significant byte first).
module vidcmd_copycap
    import vidcmd_pkg::*;
#(
    parameter int AW = ADDR_BYTES,
    localparam int NB = 2 * AW + 1,
    localparam int IDX_W = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cp_en,
    input  logic [IDX_W-1:0] cp_idx,
    input  logic [7:0]       cp_data,
    output logic             copy_valid,
    output logic [8*AW-1:0]  copy_src,
    output logic [7:0]       copy_count,
    output logic [8*AW-1:0]  copy_dst
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

    logic [NB-1:0][7:0] pay;

    // Payload store and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay        <= '0;
            copy_valid <= 1'b0;
        end else begin
            copy_valid <= cp_en && (cp_idx == LAST_IDX);
            if (cp_en) pay[cp_idx] <= cp_data;
        end
    end

    // Field assembly: payload byte k lands in the k-th most significant lane.
    for (genvar k = 0; k < AW; k++) begin : g_addr
        assign copy_src[8*(AW-1-k) +: 8] = pay[k];
        assign copy_dst[8*(AW-1-k) +: 8] = pay[AW+1+k];
    end
    assign copy_count = pay[AW];
endmodule

// File: rtl/vidcmd_decoder.sv
// Top: command stream decoder for the video control registers. Connects the
// parser, register bank and copy capture and maps live bytes to outputs.
// Assumes a byte stream with valid/ready; ready is held high.
module vidcmd_decoder
    import vidcmd_pkg::*;
#(
    parameter int TIM_N     = 12,
    parameter int REG_BYTES = 41,
    localparam int AB       = ADDR_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    output logic                  in_ready,
    output logic                  depth_24,
    output logic [8*AB-1:0]       base16_addr,
    output logic [8*AB-1:0]       base8_addr,
    output logic [TIM_N-1:0][15:0] timing_vals,
    output logic [15:0]           pix_clock,
    output logic [7:0]            blank_mode,
    output logic                  copy_valid,
    output logic [8*AB-1:0]       copy_src,
    output logic [7:0]            copy_count,
    output logic [8*AB-1:0]       copy_dst,
    output logic                  sync_err
);
    localparam int CIDX_W = $clog2(COPY_BYTES);

    logic                      wr_en;
    logic [7:0]                wr_addr;
    logic [7:0]                wr_data;
    logic                      cp_en;
    logic [CIDX_W-1:0]         cp_idx;
    logic [7:0]                cp_data;
    logic [REG_BYTES-1:0][7:0] live_bytes;
    logic                      regs_locked;
    logic                      unused_live;

    assign in_ready = 1'b1;

    vidcmd_parser #(.PAYLOAD_BYTES(COPY_BYTES)) parser_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cp_en(cp_en), .cp_idx(cp_idx), .cp_data(cp_data), .err(sync_err)
    );

    vidcmd_regbank #(.REG_BYTES(REG_BYTES)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .live(live_bytes), .locked(regs_locked)
    );

    vidcmd_copycap #(.AW(AB)) copy_i (
        .clk(clk), .rst_n(rst_n), .cp_en(cp_en), .cp_idx(cp_idx),
        .cp_data(cp_data), .copy_valid(copy_valid), .copy_src(copy_src),
        .copy_count(copy_count), .copy_dst(copy_dst)
    );

    // Timing words: high byte at the first address of each pair.
    for (genvar i = 0; i < TIM_N; i++) begin : g_tim
        assign timing_vals[i] = {live_bytes[TIM_BASE + 2*i], live_bytes[TIM_BASE + 2*i + 1]};
    end

    // Base addresses: most significant byte at the lowest address.
    for (genvar b = 0; b < AB; b++) begin : g_base
        assign base16_addr[8*(AB-1-b) +: 8] = live_bytes[BASE16_REG + b];
        assign base8_addr[8*(AB-1-b) +: 8]  = live_bytes[BASE8_REG + b];
    end

    assign pix_clock  = {live_bytes[PIXCLK_REG + 1], live_bytes[PIXCLK_REG]};
    assign blank_mode = live_bytes[BLANK_REG];
    assign depth_24   = live_bytes[DEPTH_REG][0];
    assign unused_live = ^{live_bytes, regs_locked};
endmodule

// File: rtl/vidcmd_checks.sv
// Checker: temporal properties of the decoder, bound to the top module.
module vidcmd_checks #(
    parameter int TIM_N = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   sync_err,
    input logic                   copy_valid,
    input logic                   regs_locked,
    input logic [23:0]            base16_addr,
    input logic [23:0]            base8_addr,
    input logic [TIM_N-1:0][15:0] timing_vals,
    input logic [15:0]            pix_clock,
    input logic [7:0]             blank_mode,
    input logic                   depth_24
);
    // Error flag never clears once set (R9).
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err);

    // Error only rises after an accepted byte (R9).
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> $past(in_valid));

    // Copy event lasts one cycle (R8).
    assert_copy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |=> !copy_valid);

    // Copy event follows an accepted byte (R8).
    assert_copy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> $past(in_valid));

    // Live outputs hold while locked through the previous edge (R3).
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_locked && $past(regs_locked)) |->
            ($stable(base16_addr) && $stable(base8_addr) && $stable(timing_vals)
             && $stable(pix_clock) && $stable(blank_mode) && $stable(depth_24)));

    // Live outputs move only after an accepted byte (R2).
    assert_live_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |->
            ($stable(base16_addr) && $stable(base8_addr) && $stable(timing_vals)
             && $stable(pix_clock) && $stable(blank_mode) && $stable(depth_24)));
endmodule

bind vidcmd_decoder vidcmd_checks #(.TIM_N(TIM_N)) chk_i (.*);

// File: tb/vidcmd_decoder_tb_top.sv
// Bench: scoreboard for copy events plus direct checks of live registers.
module vidcmd_decoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, depth_24, copy_valid, sync_err;
    logic [23:0] base16_addr, base8_addr, copy_src, copy_dst;
    logic [11:0][15:0] timing_vals;
    logic [15:0] pix_clock;
    logic [7:0] blank_mode, copy_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic [23:0] src;
        logic [7:0]  cnt;
        logic [23:0] dst;
    } copy_item_t;
    copy_item_t exp_q[$];

    always #5 clk = ~clk;

    vidcmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .depth_24(depth_24), .base16_addr(base16_addr),
        .base8_addr(base8_addr), .timing_vals(timing_vals), .pix_clock(pix_clock),
        .blank_mode(blank_mode), .copy_valid(copy_valid), .copy_src(copy_src),
        .copy_count(copy_count), .copy_dst(copy_dst), .sync_err(sync_err)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one byte; called at a falling edge, returns at the next one.
    task automatic send(logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wreg(logic [7:0] a, logic [7:0] d);
        send(8'hAF); send(8'h20); send(a); send(d);
    endtask

    // Driver: push the expected copy event, then stream the command.
    task automatic copy_cmd(logic [23:0] s, logic [7:0] n, logic [23:0] d);
        exp_q.push_back('{src: s, cnt: n, dst: d});
        send(8'hAF); send(8'h6A);
        send(s[23:16]); send(s[15:8]); send(s[7:0]);
        send(n);
        send(d[23:16]); send(d[15:8]); send(d[7:0]);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: ready on every accepted byte, and copy events against the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (in_valid) check("R10 in_ready", {63'd0, in_ready}, 64'd1);
            if (copy_valid) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected copy", 64'd1, 64'd0);
                end else begin
                    copy_item_t e;
                    e = exp_q.pop_front();
                    check("R8 copy fields", {8'd0, copy_src, copy_count, copy_dst},
                          {8'd0, e.src, e.cnt, e.dst});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 blank", {56'd0, blank_mode}, 64'd0);
        check("R1 base16", {40'd0, base16_addr}, 64'd0);
        check("R1 flags", {60'd0, sync_err, copy_valid, depth_24, in_ready}, 64'd1);
        check("R1 timing0", {48'd0, timing_vals[0]}, 64'd0);

        // R2 / R7 immediate writes
        wreg(8'h1F, 8'h05);
        check("R2 R7 blank", {56'd0, blank_mode}, 64'h05);
        wreg(8'h00, 8'h01);
        check("R7 depth", {63'd0, depth_24}, 64'd1);

        // R5 high byte first
        wreg(8'h01, 8'h12); wreg(8'h02, 8'h34);
        check("R5 timing0", {48'd0, timing_vals[0]}, 64'h1234);
        wreg(8'h17, 8'hAB); wreg(8'h18, 8'hCD);
        check("R5 timing11", {48'd0, timing_vals[11]}, 64'hABCD);

        // R6 low byte first
        wreg(8'h1B, 8'h60); wreg(8'h1C, 8'h1E);
        check("R6 pix_clock", {48'd0, pix_clock}, 64'h1E60);

        // R4 base addresses
        wreg(8'h20, 8'h01); wreg(8'h21, 8'h02); wreg(8'h22, 8'h03);
        check("R4 base16", {40'd0, base16_addr}, 64'h010203);
        wreg(8'h26, 8'h0A); wreg(8'h27, 8'h0B); wreg(8'h28, 8'h0C);
        check("R4 base8", {40'd0, base8_addr}, 64'h0A0B0C);

        // R3 lock, stage, unlock
        wreg(8'hFF, 8'h00);
        wreg(8'h1F, 8'h07); wreg(8'h21, 8'hFF); wreg(8'h03, 8'hBE);
        check("R3 blank held", {56'd0, blank_mode}, 64'h05);
        check("R3 base16 held", {40'd0, base16_addr}, 64'h010203);
        check("R3 timing1 held", {48'd0, timing_vals[1]}, 64'h0000);
        wreg(8'hFF, 8'hFF);
        check("R3 blank commit", {56'd0, blank_mode}, 64'h07);
        check("R3 base16 commit", {40'd0, base16_addr}, 64'h01FF03);
        check("R3 timing1 commit", {48'd0, timing_vals[1]}, 64'hBE00);

        // R11 odd lock data and unmapped address
        wreg(8'hFF, 8'h55);
        wreg(8'h1D, 8'h77);
        check("R11 pix unchanged", {48'd0, pix_clock}, 64'h1E60);
        check("R11 blank unchanged", {56'd0, blank_mode}, 64'h07);
        wreg(8'h1F, 8'h01);
        check("R11 still unlocked", {56'd0, blank_mode}, 64'h01);

        // R8 back-to-back copies
        copy_cmd(24'h112233, 8'h04, 24'h445566);
        copy_cmd(24'hABCDEF, 8'hFF, 24'h000001);
        repeat (3) @(negedge clk);
        check("R8 queue drained", {32'd0, 32'(exp_q.size())}, 64'd0);
        check("R9 no error on good stream", {63'd0, sync_err}, 64'd0);

        // R9 unknown opcode, junk, then resync
        send(8'hAF); send(8'h99);
        check("R9 bad opcode", {63'd0, sync_err}, 64'd1);
        send(8'h00); send(8'h12);
        wreg(8'h1F, 8'h00);
        check("R9 resync write", {56'd0, blank_mode}, 64'h00);
        copy_cmd(24'h010101, 8'h02, 24'h030303);
        repeat (3) @(negedge clk);
        check("R9 sticky", {63'd0, sync_err}, 64'd1);
        check("R8 queue drained end", {32'd0, 32'(exp_q.size())}, 64'd0);

        summary();
    end
endmodule